// File: doc/BRIEF.md
# Serial Gain Word Receiver

This block takes an 8-bit gain setting from a three-wire serial link made of a data line, a serial clock and an enable. It holds the setting in a parallel gain latch whose output drives the gain control of a variable-gain stage. The previous setting stays active while a new word is shifted in. A rising enable makes the new word active in one step, so the gain never passes through a partly loaded value.

All serial inputs are sampled by a faster system clock through two-stage synchronizers. Edges are found by comparing the newest synchronized sample with the one before it. A separate active-low power-down line is also synchronized and reported as an amplifier-on status. It has no effect on the stored gain. A sticky flag reports a load that did not contain exactly eight serial clocks, and a one-cycle pulse marks every change of the active gain value.

Top module: `serial_gain_rx`

## Requirements
- R1: During reset and after it, with enable held low, the active gain code is 0, the update pulse is low and the error flag is low.
- R2: Bits are shifted most-significant first. After eight serial clocks with enable low, a rising enable makes the shifted word the active gain code.
- R3: While enable is low, the active gain code keeps the last word latched, including partway through a load.
- R4: While enable is high, serial clock and data are ignored. A later enable fall and rise with no serial clocks in between leaves the gain at the word previously latched.
- R5: A data bit is sampled on the rising serial clock edge and enters the word on the falling edge. A data change while the serial clock is high has no effect.
- R6: The amplifier-on output follows the active-low power-down input (1 = powered up) after synchronization. Toggling power-down leaves the active gain code unchanged.
- R7: The update output pulses high for exactly one system clock when a rising enable changes the gain code value. It stays low when the new word equals the old one.
- R8: If enable rises after a serial clock count other than eight, the latch still takes the current shift register contents and the sticky error flag sets. With more than eight clocks, the last eight bits are kept.
- R9: A falling enable clears the error flag and restarts the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_en | input | 1 | Load enable: low while a word is shifted in, rising edge latches the word |
| ser_dat | input | 1 | Serial data, most significant bit first |
| pwr_n | input | 1 | Power-down request, active low, asynchronous |
| gain_code | output | WORD_W | Active gain setting |
| gain_update | output | 1 | One-cycle pulse when gain_code changes value |
| count_err | output | 1 | Sticky flag: last load had the wrong number of serial clocks |
| amp_on | output | 1 | Synchronized power state, 1 = amplifier enabled |

## Verification
The bench uses the defaults: an 8-bit word and two synchronizer stages. Each serial phase is held for several system clocks, so every edge passes cleanly through the synchronizers. The 8-bit word lets the bench exercise all-ones, all-zeros, alternating and repeated words, as well as short and long loads. A bench-side shift model predicts exactly what the latch should hold after a short load of three bits or a long load of ten. The 5-bit counter derived from the default width has room to count past eight, so an over-length load is reported as an error rather than wrapping to a false match.

// File: rtl/serial_gain_rx.sv
module serial_gain_rx #(
  parameter int WORD_W = 8,
  parameter int SYNC_N = 2,
  parameter int CNT_W  = $clog2(WORD_W + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_en,
  input  logic              ser_dat,
  input  logic              pwr_n,
  output logic [WORD_W-1:0] gain_code,
  output logic              gain_update,
  output logic              count_err,
  output logic              amp_on
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [SYNC_N-1:0] sck_sy, en_sy, dat_sy, pd_sy;
  logic              sck_q, en_q, mbit;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sy <= '0;
      en_sy  <= '1;
      dat_sy <= '0;
      pd_sy  <= '0;
      sck_q  <= 1'b0;
      en_q   <= 1'b1;
    end else begin
      sck_sy <= {sck_sy[SYNC_N-2:0], ser_clk};
      en_sy  <= {en_sy[SYNC_N-2:0], ser_en};
      dat_sy <= {dat_sy[SYNC_N-2:0], ser_dat};
      pd_sy  <= {pd_sy[SYNC_N-2:0], pwr_n};
      sck_q  <= sck_sy[SYNC_N-1];
      en_q   <= en_sy[SYNC_N-1];
    end
  end

  wire sck_s    = sck_sy[SYNC_N-1];
  wire en_s     = en_sy[SYNC_N-1];
  wire sck_rise = sck_s & ~sck_q & ~en_s;
  wire sck_fall = ~sck_s & sck_q & ~en_s;
  wire en_rise  = en_s & ~en_q;
  wire en_fall  = ~en_s & en_q;

  assign amp_on = pd_sy[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mbit        <= 1'b0;
      shreg       <= '0;
      cnt         <= '0;
      gain_code   <= '0;
      gain_update <= 1'b0;
      count_err   <= 1'b0;
    end else begin
      if (sck_rise) mbit <= dat_sy[SYNC_N-1];
      if (sck_fall) shreg <= {shreg[WORD_W-2:0], mbit};

      if (en_fall)
        cnt <= '0;
      else if (sck_fall && cnt != CNT_MAX)
        cnt <= cnt + 1'b1;

      if (en_rise) begin
        gain_code   <= shreg;
        gain_update <= (shreg != gain_code);
        count_err   <= (cnt != CNT_FULL);
      end else begin
        gain_update <= 1'b0;
        if (en_fall) count_err <= 1'b0;
      end
    end
  end

  a_r3_hold_gain: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rise |=> $stable(gain_code));

  a_r4_shift_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en_s |=> $stable(shreg));

  a_r7_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    gain_update |-> (gain_code != $past(gain_code)));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    gain_update |=> !gain_update);

  a_r8_err_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (count_err && !$past(count_err)) |-> $past(en_rise));

  a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> !count_err);

endmodule

// File: tb/serial_gain_rx_bench.sv
module serial_gain_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_en = 1'b0, ser_dat = 1'b0, pwr_n = 1'b1;
  logic [7:0] gain_code;
  logic       gain_update, count_err, amp_on;

  int vectors = 0, misses = 0, pulses = 0;
  logic [7:0] exp_sh = 8'h00, exp_gain = 8'h00;

  always #2 clk = ~clk;

  serial_gain_rx u_serial_gain_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en),
    .ser_dat(ser_dat), .pwr_n(pwr_n), .gain_code(gain_code),
    .gain_update(gain_update), .count_err(count_err), .amp_on(amp_on));

  always @(posedge clk) if (gain_update) pulses++;

  localparam logic [7:0] VEC [6] = '{8'hA5, 8'h3C, 8'h3C, 8'hFF, 8'h00, 8'h81};

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    ser_dat = b; wait_n(4);
    ser_clk = 1'b1; wait_n(4);
    if (glitch) begin ser_dat = ~b; wait_n(4); end
    ser_clk = 1'b0; wait_n(4);
    exp_sh = {exp_sh[6:0], b};
  endtask

  task automatic load(input logic [7:0] w, input int nbits, input bit glitch);
    ser_en = 1'b0; wait_n(6);
    for (int i = nbits - 1; i >= 0; i--) send_bit(i < 8 ? w[i] : 1'b1, glitch);
  endtask

  task automatic rise_en;
    ser_en = 1'b1; wait_n(8);
  endtask

  initial begin
    wait_n(100000);
    misses++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int p0;
    logic [7:0] prev;
    wait_n(5);
    chk("R1 gain in reset", gain_code, 0);
    chk("R1 update in reset", gain_update, 0);
    rst_n = 1'b1; wait_n(8);
    chk("R1 gain after reset", gain_code, 0);
    chk("R1 err after reset", count_err, 0);
    chk("R6 amp_on powered", amp_on, 1);

    for (int k = 0; k < 6; k++) begin
      prev = exp_gain;
      ser_en = 1'b0; wait_n(6);
      for (int i = 7; i >= 4; i--) send_bit(VEC[k][i], 1'b0);
      chk("R3 gain held mid-load", gain_code, prev);
      for (int i = 3; i >= 0; i--) send_bit(VEC[k][i], 1'b0);
      p0 = pulses;
      rise_en;
      exp_gain = VEC[k];
      chk("R2 word latched", gain_code, exp_gain);
      chk("R7 update pulses", pulses - p0, (VEC[k] != prev) ? 1 : 0);
      chk("R8 no error on 8 bits", count_err, 0);
    end

    for (int i = 0; i < 5; i++) begin
      ser_dat = 1'b1; ser_clk = 1'b1; wait_n(4); ser_clk = 1'b0; wait_n(4);
    end
    chk("R4 gain unchanged while enable high", gain_code, exp_gain);
    ser_en = 1'b0; wait_n(6);
    p0 = pulses;
    rise_en;
    chk("R4 no shift while high", gain_code, exp_gain);
    chk("R8 err after zero clocks", count_err, 1);
    chk("R7 no pulse same value", pulses - p0, 0);

    ser_en = 1'b0; wait_n(6);
    chk("R9 err cleared on fall", count_err, 0);
    for (int i = 2; i >= 0; i--) send_bit(3'b101 >> i, 1'b0);
    rise_en;
    exp_gain = exp_sh;
    chk("R8 short load takes register", gain_code, exp_gain);
    chk("R8 err on short load", count_err, 1);

    load(8'h5A, 10, 1'b0);
    chk("R9 err cleared on new load", count_err, 0);
    rise_en;
    chk("R8 long load keeps last bits", gain_code, 8'h5A);
    chk("R8 err on long load", count_err, 1);

    load(8'hC3, 8, 1'b1);
    rise_en;
    chk("R5 data sampled on clock rise", gain_code, 8'hC3);
    chk("R5 err clear", count_err, 0);

    pwr_n = 1'b0; wait_n(8);
    chk("R6 amp_on off", amp_on, 0);
    chk("R6 gain kept in power-down", gain_code, 8'hC3);
    pwr_n = 1'b1; wait_n(8);
    chk("R6 amp_on back", amp_on, 1);
    chk("R6 gain valid after release", gain_code, 8'hC3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule